// File: doc/BRIEF.md
# Trace Line Fill Buffer

This block builds new trace lines for a trace cache. Each cycle it may accept one instruction from the fetch stream: its address, its instruction word, whether it is a conditional branch, the branch outcome and the branch target. It gathers these instructions into a private buffer. The buffer counts the instructions and the basic blocks, and records branch outcomes in program order.

A line is finished by whichever limit is reached first. One limit is the number of instructions in a line. The other is the number of basic blocks, where every conditional branch ends a block. When the line is finished, the block raises a one-cycle write to the trace cache. The write carries the line tag, the branch outcome flags, the branch mask, the fall-through and target addresses of the last block, the instruction count and every instruction word. A partly filled line is never presented on the write port.

A flush input throws away the partial line. The next instruction that is accepted then starts a fresh line.

Top module: `trace_fill_buffer`

## Requirements
- R1: After reset, `wr_valid` is low, `wr_count` is zero and the buffer is empty.
- R2: `wr_tag` equals the address of the first instruction accepted into an empty buffer.
- R3: Accepting the `LINE_INSNS`-th instruction finishes the line. The write appears on the next cycle with `wr_count` equal to `LINE_INSNS`.
- R4: Accepting the `MAX_BLOCKS`-th conditional branch finishes the line even when fewer than `LINE_INSNS` instructions are held. `wr_count` is the number of instructions held, including that branch.
- R5: Bit i of `wr_flags` is the outcome (1 = taken) of the i-th branch in the line, with bit 0 for the earliest branch. Bit i of `wr_mask` is 1 exactly when the line holds more than i branches. Flag bits outside the mask are 0.
- R6: `wr_fallthru` equals the address of the last instruction in the line plus `INSN_BYTES` (4).
- R7: `wr_target` equals the last instruction's branch target when that instruction is a branch, whether or not the branch is taken. Otherwise it equals `wr_fallthru`.
- R8: Slot i of `wr_words` (bits i*INSN_W upward) holds the i-th instruction of the line. Slots at or beyond `wr_count` are zero.
- R9: `wr_valid` is high for exactly one cycle per finished line. An instruction accepted in the cycle right after the finishing instruction starts the next line, so no cycle is lost.
- R10: When `flush` is high, no write is produced and the partial line is discarded. An instruction presented in the same cycle is dropped, even one that would have finished the line. The next accepted instruction becomes the new tag.
- R11: A cycle with `in_valid` low adds nothing to the line and does not change its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_addr | input | ADDR_W | Address of the presented instruction |
| in_word | input | INSN_W | Instruction word |
| in_is_branch | input | 1 | Instruction is a conditional branch |
| in_taken | input | 1 | Branch outcome, 1 = taken |
| in_target | input | ADDR_W | Branch target address |
| flush | input | 1 | Discard the partial line and the same-cycle instruction |
| wr_valid | output | 1 | One-cycle write strobe for a finished line |
| wr_tag | output | ADDR_W | Address of the first instruction of the line |
| wr_count | output | clog2(LINE_INSNS+1) | Number of instructions in the line |
| wr_flags | output | MAX_BLOCKS | Branch outcomes in program order |
| wr_mask | output | MAX_BLOCKS | Which flag bits hold a branch |
| wr_fallthru | output | ADDR_W | Address after the last instruction |
| wr_target | output | ADDR_W | Target of the last block |
| wr_words | output | LINE_INSNS*INSN_W | Instruction words, slot 0 in the low bits |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a flush together with an instruction that would finish the line. The bench presents a full-minus-one line and then asserts `flush` and `in_valid` together. It expects no write pulse, and it expects the next accepted instruction to become the new tag. The second pair is the write of one line together with the first instruction of the next line. The bench sends finishing instructions immediately followed by further instructions, both in directed sequences and in a long random run, and a behavioural queue model checks every output on every cycle.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

    // What the current cycle does to the line being assembled.
    typedef enum logic [1:0] {
        FILL_KEEP   = 2'd0,
        FILL_FULL   = 2'd1,
        FILL_BLOCKS = 2'd2,
        FILL_DROP   = 2'd3
    } fill_evt_e;

endpackage

// File: rtl/tfb_fill_ctl.sv
module tfb_fill_ctl
    import tfb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_INSNS = 6,
    localparam int CNT_W     = $clog2(LINE_INSNS + 1),
    localparam int SLOT_W    = (LINE_INSNS > 1) ? $clog2(LINE_INSNS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              flush,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              blocks_done,
    output logic              take,
    output logic [SLOT_W-1:0] slot,
    output logic [CNT_W-1:0]  count_next,
    output logic [ADDR_W-1:0] tag_next,
    output fill_evt_e         evt,
    output logic              clear
);

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] tag;
    } ctl_t;

    ctl_t st_d, st_q;
    logic full;

    always_comb begin
        take       = in_valid && !flush;
        slot       = SLOT_W'(st_q.count);
        count_next = st_q.count + CNT_W'(take);
        tag_next   = (take && st_q.count == '0) ? in_addr : st_q.tag;
        full       = take && (st_q.count == CNT_W'(LINE_INSNS - 1));

        if (flush)                     evt = FILL_DROP;
        else if (full)                 evt = FILL_FULL;
        else if (take && blocks_done)  evt = FILL_BLOCKS;
        else                           evt = FILL_KEEP;

        clear      = (evt != FILL_KEEP);
        st_d.count = clear ? '0 : count_next;
        st_d.tag   = tag_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count < CNT_W'(LINE_INSNS));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.count == '0));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flush) |=> $stable(st_q.count));

endmodule

// File: rtl/tfb_branch_track.sv
module tfb_branch_track #(
    parameter int MAX_BLOCKS = 3,
    localparam int BR_W      = $clog2(MAX_BLOCKS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic                  is_branch,
    input  logic                  taken,
    input  logic                  clear,
    output logic [MAX_BLOCKS-1:0] flags_next,
    output logic [MAX_BLOCKS-1:0] mask_next,
    output logic                  blocks_done
);

    typedef struct packed {
        logic [BR_W-1:0]       nbr;
        logic [MAX_BLOCKS-1:0] flags;
    } br_t;

    br_t st_d, st_q;
    logic            br_take;
    logic [BR_W-1:0] nbr_m;

    always_comb begin
        br_take    = take && is_branch;
        flags_next = st_q.flags;
        for (int i = 0; i < MAX_BLOCKS; i++) begin
            if (br_take && st_q.nbr == BR_W'(i)) flags_next[i] = taken;
        end
        nbr_m       = st_q.nbr + BR_W'(br_take);
        blocks_done = br_take && (st_q.nbr == BR_W'(MAX_BLOCKS - 1));

        st_d.nbr   = clear ? '0 : nbr_m;
        st_d.flags = clear ? '0 : flags_next;
    end

    for (genvar g = 0; g < MAX_BLOCKS; g++) begin : g_mask
        assign mask_next[g] = (nbr_m > BR_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    nbr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nbr < BR_W'(MAX_BLOCKS));

    // R11
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clear) |=> $stable(st_q.flags));

endmodule

// File: rtl/tfb_word_store.sv
module tfb_word_store #(
    parameter int INSN_W     = 32,
    parameter int LINE_INSNS = 6,
    localparam int SLOT_W    = (LINE_INSNS > 1) ? $clog2(LINE_INSNS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wen,
    input  logic [SLOT_W-1:0]            slot,
    input  logic [INSN_W-1:0]            word,
    input  logic                         clear,
    output logic [LINE_INSNS*INSN_W-1:0] view
);

    for (genvar g = 0; g < LINE_INSNS; g++) begin : g_slot
        logic [INSN_W-1:0] word_d, word_q, merged;

        always_comb begin
            merged = (wen && slot == SLOT_W'(g)) ? word : word_q;
            word_d = clear ? '0 : merged;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign view[g*INSN_W +: INSN_W] = merged;

        // R8
        slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> (word_q == '0));
    end

endmodule

// File: rtl/trace_fill_buffer.sv
module trace_fill_buffer
    import tfb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_W     = 32,
    parameter int LINE_INSNS = 6,
    parameter int MAX_BLOCKS = 3,
    parameter int INSN_BYTES = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [ADDR_W-1:0]                   in_addr,
    input  logic [INSN_W-1:0]                   in_word,
    input  logic                                in_is_branch,
    input  logic                                in_taken,
    input  logic [ADDR_W-1:0]                   in_target,
    input  logic                                flush,
    output logic                                wr_valid,
    output logic [ADDR_W-1:0]                   wr_tag,
    output logic [$clog2(LINE_INSNS+1)-1:0]     wr_count,
    output logic [MAX_BLOCKS-1:0]               wr_flags,
    output logic [MAX_BLOCKS-1:0]               wr_mask,
    output logic [ADDR_W-1:0]                   wr_fallthru,
    output logic [ADDR_W-1:0]                   wr_target,
    output logic [LINE_INSNS*INSN_W-1:0]        wr_words
);

    localparam int CNT_W  = $clog2(LINE_INSNS + 1);
    localparam int SLOT_W = (LINE_INSNS > 1) ? $clog2(LINE_INSNS) : 1;

    typedef struct packed {
        logic                         valid;
        logic [ADDR_W-1:0]            tag;
        logic [CNT_W-1:0]             count;
        logic [MAX_BLOCKS-1:0]        flags;
        logic [MAX_BLOCKS-1:0]        mask;
        logic [ADDR_W-1:0]            fall;
        logic [ADDR_W-1:0]            target;
        logic [LINE_INSNS*INSN_W-1:0] words;
    } line_t;

    logic                         take, clear, blocks_done;
    logic [SLOT_W-1:0]            slot;
    logic [CNT_W-1:0]             count_next;
    logic [ADDR_W-1:0]            tag_next, fall_now;
    logic [MAX_BLOCKS-1:0]        flags_next, mask_next;
    logic [LINE_INSNS*INSN_W-1:0] view;
    fill_evt_e                    evt;
    line_t                        out_d, out_q;

    tfb_fill_ctl #(
        .ADDR_W     (ADDR_W),
        .LINE_INSNS (LINE_INSNS)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .flush       (flush),
        .in_addr     (in_addr),
        .blocks_done (blocks_done),
        .take        (take),
        .slot        (slot),
        .count_next  (count_next),
        .tag_next    (tag_next),
        .evt         (evt),
        .clear       (clear)
    );

    tfb_branch_track #(
        .MAX_BLOCKS (MAX_BLOCKS)
    ) u_br (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .is_branch   (in_is_branch),
        .taken       (in_taken),
        .clear       (clear),
        .flags_next  (flags_next),
        .mask_next   (mask_next),
        .blocks_done (blocks_done)
    );

    tfb_word_store #(
        .INSN_W     (INSN_W),
        .LINE_INSNS (LINE_INSNS)
    ) u_words (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (take),
        .slot  (slot),
        .word  (in_word),
        .clear (clear),
        .view  (view)
    );

    always_comb begin
        fall_now    = in_addr + ADDR_W'(INSN_BYTES);
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (evt == FILL_FULL || evt == FILL_BLOCKS) begin
            out_d.valid  = 1'b1;
            out_d.tag    = tag_next;
            out_d.count  = count_next;
            out_d.flags  = flags_next;
            out_d.mask   = mask_next;
            out_d.fall   = fall_now;
            out_d.target = in_is_branch ? in_target : fall_now;
            out_d.words  = view;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign wr_valid    = out_q.valid;
    assign wr_tag      = out_q.tag;
    assign wr_count    = out_q.count;
    assign wr_flags    = out_q.flags;
    assign wr_mask     = out_q.mask;
    assign wr_fallthru = out_q.fall;
    assign wr_target   = out_q.target;
    assign wr_words    = out_q.words;

    // R3 R4
    close_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_count == CNT_W'(LINE_INSNS) || wr_mask[MAX_BLOCKS-1]));

    // R5
    flags_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_flags & ~wr_mask) == '0));

    // R5
    mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_mask & (wr_mask + 1'b1)) == '0));

    // R10
    flush_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !wr_valid);

    // R9
    write_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wr_valid);

endmodule

// File: tb/tb_trace_fill_buffer.sv
module tb_trace_fill_buffer;
    localparam int AW = 32, IW = 32, N = 6, M = 3, IB = 4;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_is_branch = 0, in_taken = 0, flush = 0;
    logic [AW-1:0] in_addr = '0, in_target = '0;
    logic [IW-1:0] in_word = '0;
    logic wr_valid;
    logic [AW-1:0] wr_tag, wr_fallthru, wr_target;
    logic [CW-1:0] wr_count;
    logic [M-1:0] wr_flags, wr_mask;
    logic [N*IW-1:0] wr_words;

    trace_fill_buffer #(.ADDR_W(AW), .INSN_W(IW), .LINE_INSNS(N),
                        .MAX_BLOCKS(M), .INSN_BYTES(IB)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_word(in_word), .in_is_branch(in_is_branch), .in_taken(in_taken),
        .in_target(in_target), .flush(flush), .wr_valid(wr_valid),
        .wr_tag(wr_tag), .wr_count(wr_count), .wr_flags(wr_flags),
        .wr_mask(wr_mask), .wr_fallthru(wr_fallthru), .wr_target(wr_target),
        .wr_words(wr_words));

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [AW-1:0] pc = 32'h0000_1000;

    // behavioural model state
    logic [IW-1:0] m_words[$];
    bit            m_br[$];
    logic [AW-1:0] m_tag;
    bit            e_valid, e_full;
    logic [AW-1:0] e_tag, e_fall, e_tgt;
    int            e_count;
    logic [M-1:0]  e_flags, e_mask;
    logic [N*IW-1:0] e_words;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(bit v, logic [AW-1:0] a, logic [IW-1:0] w, bit br, bit tk,
                        logic [AW-1:0] tg, bit fl, string req);
        in_valid = v; in_addr = a; in_word = w; in_is_branch = br;
        in_taken = tk; in_target = tg; flush = fl;
        @(posedge clk);
        e_valid = 0;
        if (fl) begin
            m_words.delete(); m_br.delete();
        end else if (v) begin
            if (m_words.size() == 0) m_tag = a;
            m_words.push_back(w);
            if (br) m_br.push_back(tk);
            if (m_words.size() == N || m_br.size() == M) begin
                e_valid = 1; e_full = (m_words.size() == N);
                e_tag = m_tag; e_count = m_words.size();
                e_flags = '0; e_mask = '0;
                foreach (m_br[i]) begin e_flags[i] = m_br[i]; e_mask[i] = 1'b1; end
                e_fall = a + IB;
                e_tgt  = br ? tg : a + IB;
                e_words = '0;
                foreach (m_words[i]) e_words[i*IW +: IW] = m_words[i];
                m_words.delete(); m_br.delete();
            end
        end
        @(negedge clk);
        check(req, "wr_valid", 64'(wr_valid), 64'(e_valid));
        if (e_valid && wr_valid) begin
            check("R2", "tag", 64'(wr_tag), 64'(e_tag));
            check(e_full ? "R3" : "R4", "count", 64'(wr_count), 64'(e_count));
            check("R5", "flags", 64'(wr_flags), 64'(e_flags));
            check("R5", "mask", 64'(wr_mask), 64'(e_mask));
            check("R6", "fallthru", 64'(wr_fallthru), 64'(e_fall));
            check("R7", "target", 64'(wr_target), 64'(e_tgt));
            for (int i = 0; i < N; i++)
                check("R8", $sformatf("word%0d", i), 64'(wr_words[i*IW +: IW]),
                      64'(e_words[i*IW +: IW]));
        end
    endtask

    task automatic send(bit br, bit tk, string req);
        logic [AW-1:0] tg;
        tg = {$urandom(), 2'b00};
        step(1, pc, $urandom(), br, tk, tg, 0, req);
        pc = (br && tk) ? tg : pc + IB;
    endtask

    task automatic idle(string req);
        step(0, '0, '0, 0, 0, '0, 0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R9 watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset
        check("R1", "wr_valid after reset", 64'(wr_valid), 64'd0);
        check("R1", "wr_count after reset", 64'(wr_count), 64'd0);
        idle("R1");

        // R3: line closed by instruction count
        for (int i = 0; i < N; i++) send(0, 0, "R3");
        idle("R3");

        // R4: closed by third branch, count 5, last target from branch
        send(0, 0, "R4"); send(1, 1, "R4"); send(0, 0, "R4");
        send(1, 0, "R4"); send(1, 1, "R4");

        // R5/R7: two branches then full, last non-branch
        send(1, 0, "R5"); send(1, 1, "R5");
        for (int i = 0; i < N - 2; i++) send(0, 0, "R5");

        // R7: full line ending on a not-taken branch
        for (int i = 0; i < N - 1; i++) send(0, 0, "R7");
        send(1, 0, "R7");

        // R9: back-to-back lines with no gap
        for (int i = 0; i < 2 * M; i++) send(1, i[0], "R9");
        for (int i = 0; i < N; i++) send(0, 0, "R9");

        // R10: flush of a partial line, then new tag
        for (int i = 0; i < 3; i++) send(0, 0, "R10");
        step(0, '0, '0, 0, 0, '0, 1, "R10");
        for (int i = 0; i < N; i++) send(0, 0, "R10");
        // R10: flush in same cycle as the finishing instruction
        for (int i = 0; i < N - 1; i++) send(0, 0, "R10");
        step(1, pc, 32'hDEAD_BEEF, 0, 0, '0, 1, "R10");
        for (int i = 0; i < N; i++) send(0, 0, "R10");

        // R11: idle cycles interleaved in a line
        for (int i = 0; i < N; i++) begin send(i == 2, 1, "R11"); idle("R11"); idle("R11"); end

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 4) step(($urandom_range(0, 1) == 1), pc, $urandom(), 0, 0, '0, 1, "R10");
            else if (r < 20) idle("R11");
            else send(($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1), "R9");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule